// File: doc/BRIEF.md
# DDR2 Write-Recovery Precharge Gate

This block sits beside the command scheduler of a DDR2 memory controller. It watches every command that goes out to the device and keeps, for each bank, the timing that decides when that bank may be closed again and when it may be reopened. The scheduler reads the per-bank "precharge allowed" and "activate allowed" outputs, plus one "all-bank precharge allowed" output, and holds back any command whose gate is low.

A WRITE makes its bank wait until the burst has been written and the write-recovery time has passed. The data burst begins after the write latency, which is the additive latency plus the CAS latency minus one. It lasts half the burst length in clock cycles. Write recovery counts from the first rising edge after the last data pair. Only a precharge to the bank that was written has to wait. When the WRITE carries the auto-precharge bit, the block closes the bank by itself after recovery and then applies the precharge period. After any precharge, the bank cannot be activated again until the precharge period has passed. A sticky flag records every PRECHARGE or ACTIVATE that was issued while its gate was low.

Latencies, burst length and the two recovery times arrive as programmed inputs. The block applies the values present when a WRITE or PRECHARGE is accepted.

Top module: `ddr2_wr_recovery_gate`

## Requirements
- R1: For a WRITE accepted at edge T, with write latency WL = add_lat + cas_lat - 1 and a burst of BL/2 cycles, pre_ok of that bank is low for commands at edges T+1 up to T+WL+BL/2+t_wr-1. It is high again for the edge T+WL+BL/2+t_wr.
- R2: A WRITE to one bank leaves pre_ok and act_ok of every other bank unchanged.
- R3: pre_all_ok is high exactly when pre_ok is high for every bank. A PRECHARGE with a10 high applies to all banks.
- R4: A PRECHARGE accepted at edge P, to one bank or to all banks, holds act_ok of each affected bank low until it goes high for the edge P+t_rp.
- R5: A WRITE with a10 high (auto precharge) keeps pre_ok and act_ok of its bank low until the internal close at edge T+WL+BL/2+t_wr. act_ok then rises for the edge that is t_rp cycles later.
- R6: A new WRITE to a bank whose recovery is still running restarts the recovery from the new burst end.
- R7: violation is set by a PRECHARGE (cmd 2'b11) whose gate (pre_ok of its bank, or pre_all_ok when a10 is high) is low, or by an ACTIVATE (cmd 2'b01) while act_ok of its bank is low. Once set, it stays set until reset. The command codes are NOP 2'b00 and WRITE 2'b10.
- R8: After reset, every pre_ok and act_ok bit and pre_all_ok are high, and violation is low.
- R9: bl8 high selects a burst length of 8 (four data cycles), and bl8 low selects 4 (two data cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command on this edge: 00 NOP, 01 ACTIVATE, 10 WRITE, 11 PRECHARGE |
| bank | input | BANK_W (3) | Bank address of the command |
| a10 | input | 1 | Auto precharge on WRITE; all-bank select on PRECHARGE |
| cas_lat | input | LAT_W (3) | Programmed CAS latency in cycles |
| add_lat | input | LAT_W (3) | Programmed additive latency in cycles |
| bl8 | input | 1 | 1 selects burst length 8, 0 selects 4 |
| t_wr | input | T_W (4) | Write-recovery time in cycles |
| t_rp | input | T_W (4) | Precharge period in cycles |
| pre_ok | output | NUM_BANKS (8) | Per-bank: a PRECHARGE on the next edge is legal |
| pre_all_ok | output | 1 | An all-bank PRECHARGE on the next edge is legal |
| act_ok | output | NUM_BANKS (8) | Per-bank: an ACTIVATE on the next edge is legal |
| violation | output | 1 | Sticky flag for an early PRECHARGE or ACTIVATE |

## Verification
The assertions check on every cycle the local rules of each bank. They confirm that a WRITE closes the precharge gate on the next cycle, that a running recovery count falls by exactly one per cycle, and that a PRECHARGE or an auto-precharging WRITE closes the activate gate. They also confirm that an early command raises the violation flag and that the flag never drops. The exact cycle on which each gate reopens for a given latency, burst length and recovery setting can only be shown by the bench's scenarios. The same holds for a rewrite restarting the window, for the isolation between banks, and for the auto-precharge chain of recovery followed by the precharge period. The bench compares each of those against a timeline model.

// File: rtl/ddr2_wrg_pkg.sv
package ddr2_wrg_pkg;
   typedef enum logic [1:0] {
      CMD_NOP   = 2'b00,
      CMD_ACT   = 2'b01,
      CMD_WRITE = 2'b10,
      CMD_PRE   = 2'b11
   } wrg_cmd_e;
endpackage

// File: rtl/ddr2_wrg_lat_calc.sv
// Computes the recovery-counter load for a WRITE: write latency + data cycles + t_wr - 1.
module ddr2_wrg_lat_calc #(
   parameter int LAT_W    = 3,
   parameter int T_W      = 4,
   parameter int CNT_W    = 6,
   parameter bit ALLOW_BL8 = 1'b1
) (
   input  logic [LAT_W-1:0] cas_lat,
   input  logic [LAT_W-1:0] add_lat,
   input  logic             bl8,
   input  logic [T_W-1:0]   t_wr,
   output logic [CNT_W-1:0] load_val
);
   logic [CNT_W-1:0] data_cyc;
   logic [CNT_W-1:0] wl;

   generate
      if (ALLOW_BL8) begin : g_bl_sel
         assign data_cyc = bl8 ? CNT_W'(4) : CNT_W'(2);
      end else begin : g_bl4_only
         logic unused_bl8;
         assign unused_bl8 = bl8;
         assign data_cyc   = CNT_W'(2);
      end
   endgenerate

   // R1: write latency = additive + CAS - 1
   assign wl       = CNT_W'(add_lat) + CNT_W'(cas_lat) - CNT_W'(1);
   assign load_val = wl + data_cyc + CNT_W'(t_wr) - CNT_W'(1);
endmodule

// File: rtl/ddr2_wrg_bank.sv
// Per-bank recovery and precharge-period tracking.
module ddr2_wrg_bank #(
   parameter int T_W   = 4,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic             wr_auto,
   input  logic             pre_hit,
   input  logic [CNT_W-1:0] load_val,
   input  logic [T_W-1:0]   t_rp,
   output logic             pre_ok,
   output logic             act_ok
);
   logic [CNT_W-1:0] rec_q;
   logic [T_W-1:0]   rp_q;
   logic             auto_q;
   logic             auto_close;
   logic [T_W-1:0]   rp_load;

   assign auto_close = auto_q && (rec_q == '0);
   assign rp_load    = (t_rp == '0) ? '0 : t_rp - T_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rec_q  <= '0;
         auto_q <= 1'b0;
      end else if (wr_hit) begin
         rec_q  <= load_val;          // R6: a rewrite restarts recovery
         auto_q <= wr_auto;
      end else begin
         if (rec_q != '0) rec_q <= rec_q - CNT_W'(1);
         if (auto_close)  auto_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rp_q <= '0;
      else if (pre_hit || auto_close)
         rp_q <= rp_load;
      else if (rp_q != '0)
         rp_q <= rp_q - T_W'(1);
   end

   assign pre_ok = (rec_q == '0) && !auto_q;
   assign act_ok = (rp_q == '0) && !auto_q;

   a_r1_write_blocks_pre: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit && (load_val != '0) |=> !pre_ok);
   a_r6_rec_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_q != '0) && !wr_hit |=> rec_q == $past(rec_q) - CNT_W'(1));
   a_r4_pre_blocks_act: assert property (@(posedge clk) disable iff (!rst_n)
      pre_hit && (t_rp > T_W'(1)) |=> !act_ok);
   a_r5_auto_blocks_act: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit && wr_auto |=> !act_ok && !pre_ok);
endmodule

// File: rtl/ddr2_wr_recovery_gate.sv
module ddr2_wr_recovery_gate
   import ddr2_wrg_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int LAT_W     = 3,
   parameter int T_W       = 4,
   parameter bit ALLOW_BL8 = 1'b1,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           cmd,
   input  logic [BANK_W-1:0]    bank,
   input  logic                 a10,
   input  logic [LAT_W-1:0]     cas_lat,
   input  logic [LAT_W-1:0]     add_lat,
   input  logic                 bl8,
   input  logic [T_W-1:0]       t_wr,
   input  logic [T_W-1:0]       t_rp,
   output logic [NUM_BANKS-1:0] pre_ok,
   output logic                 pre_all_ok,
   output logic [NUM_BANKS-1:0] act_ok,
   output logic                 violation
);
   localparam int SUM_W = ((LAT_W + 1) > T_W) ? (LAT_W + 1) : T_W;
   localparam int CNT_W = SUM_W + 2;

   generate
      if (NUM_BANKS < 2 || NUM_BANKS > 16) begin : g_bad_banks
         $error("NUM_BANKS must be between 2 and 16");
      end
      if (LAT_W < 2 || T_W < 2) begin : g_bad_widths
         $error("LAT_W and T_W must be at least 2");
      end
   endgenerate

   wrg_cmd_e         cmd_e;
   logic [CNT_W-1:0] load_val;
   logic             is_wr, is_pre, is_act, pre_all;
   logic             bad_cmd;
   logic             viol_q;

   assign cmd_e   = wrg_cmd_e'(cmd);
   assign is_wr   = (cmd_e == CMD_WRITE);
   assign is_pre  = (cmd_e == CMD_PRE);
   assign is_act  = (cmd_e == CMD_ACT);
   assign pre_all = is_pre && a10;

   ddr2_wrg_lat_calc #(
      .LAT_W(LAT_W), .T_W(T_W), .CNT_W(CNT_W), .ALLOW_BL8(ALLOW_BL8)
   ) u_lat (
      .cas_lat(cas_lat), .add_lat(add_lat), .bl8(bl8), .t_wr(t_wr),
      .load_val(load_val)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = (32'(bank) == b);
      ddr2_wrg_bank #(.T_W(T_W), .CNT_W(CNT_W)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .wr_hit(is_wr && sel), .wr_auto(a10),
         .pre_hit(pre_all || (is_pre && sel)),
         .load_val(load_val), .t_rp(t_rp),
         .pre_ok(pre_ok[b]), .act_ok(act_ok[b])
      );
   end

   assign pre_all_ok = &pre_ok;   // R3

   assign bad_cmd = (pre_all && !pre_all_ok)
                 || (is_pre && !a10 && !pre_ok[bank])
                 || (is_act && !act_ok[bank]);

   always_ff @(posedge clk) begin
      if (!rst_n)      viol_q <= 1'b0;
      else if (bad_cmd) viol_q <= 1'b1;
   end
   assign violation = viol_q;

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      violation |=> violation);
   a_r7_early_act: assert property (@(posedge clk) disable iff (!rst_n)
      is_act && !act_ok[bank] |=> violation);
   a_r7_early_pre: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre && !a10 && !pre_ok[bank] |=> violation);
   a_r2_other_bank_pre: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr && pre_all_ok |=> $countones(pre_ok) >= NUM_BANKS - 1);
endmodule

// File: tb/ddr2_wr_recovery_gate_bench.sv
module ddr2_wr_recovery_gate_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] cmd = 2'b00;
   logic [2:0] bank = '0;
   logic a10 = 1'b0;
   logic [2:0] cas_lat = 3'd3, add_lat = 3'd0;
   logic bl8 = 1'b0;
   logic [3:0] t_wr = 4'd3, t_rp = 4'd3;
   logic [NB-1:0] pre_ok, act_ok;
   logic pre_all_ok, violation;

   ddr2_wr_recovery_gate u_ddr2_wr_recovery_gate (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .a10(a10),
      .cas_lat(cas_lat), .add_lat(add_lat), .bl8(bl8), .t_wr(t_wr), .t_rp(t_rp),
      .pre_ok(pre_ok), .pre_all_ok(pre_all_ok), .act_ok(act_ok), .violation(violation)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int edges = 0;
   always @(posedge clk) edges <= edges + 1;

   int total = 0, bad = 0;
   bit done = 1'b0;
   string tag = "R8";

   int pre_rdy[NB], act_rdy[NB], ap_end[NB], ap_rp[NB];
   bit apf[NB];
   bit viol_m;

   function automatic int rec_len();
      int half = bl8 ? 4 : 2;
      return int'(add_lat) + int'(cas_lat) - 1 + half + int'(t_wr);
   endfunction

   function automatic bit exp_pre(int b, int c);
      return (c >= pre_rdy[b]) && !(apf[b] && c <= ap_end[b]);
   endfunction

   function automatic bit exp_act(int b, int c);
      if (apf[b] && c < ap_end[b] + ap_rp[b]) return 1'b0;
      return c >= act_rdy[b];
   endfunction

   function automatic void fold_ap(int b, int c);
      if (apf[b] && c >= ap_end[b]) begin
         if (ap_end[b] + ap_rp[b] > act_rdy[b]) act_rdy[b] = ap_end[b] + ap_rp[b];
         apf[b] = 1'b0;
      end
   endfunction

   function automatic void model_reset();
      for (int b = 0; b < NB; b++) begin
         pre_rdy[b] = 0; act_rdy[b] = 0; ap_end[b] = 0; ap_rp[b] = 0; apf[b] = 0;
      end
      viol_m = 1'b0;
   endfunction

   task automatic chk(bit act, bit exp, string req, string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s [%s] %s: actual=%0b expected=%0b at edge %0d",
                  req, tag, what, act, exp, edges);
      end
   endtask

   // One cycle: check outputs for the coming edge, then drive a command for it.
   task automatic step(bit [1:0] c_cmd, int b_sel, bit c_a10);
      int c;
      bit all_ok;
      @(negedge clk);
      c = edges + 1;
      all_ok = 1'b1;
      for (int b = 0; b < NB; b++) begin
         chk(pre_ok[b], exp_pre(b, c), "R1", $sformatf("pre_ok[%0d]", b));
         chk(act_ok[b], exp_act(b, c), "R4", $sformatf("act_ok[%0d]", b));
         all_ok &= exp_pre(b, c);
      end
      chk(pre_all_ok, all_ok, "R3", "pre_all_ok");
      chk(violation, viol_m, "R7", "violation");
      cmd = c_cmd; bank = 3'(b_sel); a10 = c_a10;
      case (c_cmd)
         2'b01: if (!exp_act(b_sel, c)) viol_m = 1'b1;
         2'b10: begin
            fold_ap(b_sel, c);
            apf[b_sel] = c_a10;
            ap_end[b_sel] = c + rec_len();
            ap_rp[b_sel] = int'(t_rp);
            pre_rdy[b_sel] = c + rec_len();
         end
         2'b11: begin
            if (c_a10 ? !all_ok : !exp_pre(b_sel, c)) viol_m = 1'b1;
            for (int b = 0; b < NB; b++) begin
               if (c_a10 || b == b_sel) begin
                  fold_ap(b, c);
                  act_rdy[b] = c + int'(t_rp);
               end
            end
         end
         default: ;
      endcase
   endtask

   task automatic nops(int n);
      for (int i = 0; i < n; i++) step(2'b00, 0, 1'b0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cmd = 2'b00;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      // R8: reset state
      tag = "R8";
      do_reset();
      nops(2);

      // R1 and R2: legal precharge of another bank, then on-time precharge
      tag = "R1/R2";
      step(2'b10, 0, 1'b0);
      step(2'b11, 1, 1'b0);
      nops(5);
      step(2'b11, 0, 1'b0);
      nops(2);
      step(2'b01, 0, 1'b0);   // R4: ACTIVATE exactly t_rp after precharge
      nops(3);

      // R1 / R7: early precharge one cycle short
      tag = "R1/R7 early";
      do_reset();
      step(2'b10, 0, 1'b0);
      nops(5);
      step(2'b11, 0, 1'b0);
      nops(4);

      // R5 and R9: auto precharge with burst length 8
      tag = "R5/R9";
      do_reset();
      cas_lat = 3'd4; add_lat = 3'd1; bl8 = 1'b1; t_wr = 4'd4; t_rp = 4'd3;
      step(2'b10, 2, 1'b1);
      nops(15);
      step(2'b01, 2, 1'b0);
      nops(3);

      // R6 and R3: rewrite restarts window, all-bank precharge
      tag = "R6/R3";
      do_reset();
      cas_lat = 3'd3; add_lat = 3'd0; bl8 = 1'b0; t_wr = 4'd3; t_rp = 4'd2;
      step(2'b10, 3, 1'b0);
      nops(3);
      step(2'b10, 3, 1'b0);
      nops(6);
      step(2'b11, 0, 1'b1);
      nops(3);

      // Random phases with varying settings
      for (int ph = 0; ph < 6; ph++) begin
         tag = $sformatf("random phase %0d", ph);
         do_reset();
         cas_lat = 3'(3 + $urandom_range(3));
         add_lat = 3'($urandom_range(4));
         bl8     = 1'($urandom_range(1));
         t_wr    = 4'(2 + $urandom_range(6));
         t_rp    = 4'(1 + $urandom_range(5));
         for (int i = 0; i < 300; i++) begin
            int r = $urandom_range(99);
            int bsel = $urandom_range(NB - 1);
            bit ax = 1'($urandom_range(3) == 0);
            if (r < 55)      step(2'b00, bsel, 1'b0);
            else if (r < 70) step(2'b10, bsel, ax);
            else if (r < 85) step(2'b11, bsel, ax);
            else             step(2'b01, bsel, 1'b0);
         end
      end
      nops(1);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog [%s]: actual=hung expected=finished", tag);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule